// File: doc/BRIEF.md
# Video output timing generator

This block generates an 8-bit 4:2:2 component video byte stream in the CCIR656 style and emits one byte on every rising clock edge. Each line opens with an end-of-active-video code and then carries horizontal blanking fill. A start-of-active-video code follows, and the active samples close the line. The active samples come from an upstream source through a ready/valid byte port. On lines outside the active window, and whenever the source has no byte ready, the block sends the blanking pattern in place of samples.

The block has two timing modes. In free-running mode it starts on its own after reset and keeps going. In locked mode it stays idle until it sees an edge of the selected polarity on the frame-sync input. It then sends exactly two fields and stops. It answers only the first such edge after reset. Optional horizontal and frame sync outputs run alongside the stream. Three sticky flags mark end of field, arrival at a programmed line, and source underrun. Each flag is cleared by writing a one to its acknowledge bit. The line geometry is sampled into shadow registers at each field boundary.

Top module: `vout_timing`

## Requirements
- R1: `vid_data`, `hs_out` and `fs_out` are registered and change only on the rising clock edge. While reset is asserted, and whenever the generator is not running, `vid_data` is 0x10, the flags are 0 and `px_ready` is 0.
- R2: A timing code is the byte sequence 0xFF, 0x00, 0x00, XY. In XY, bit 7 is 1, bit 6 is F, bit 5 is V and bit 4 is H (1 for the end-of-active code, 0 for the start-of-active code). Bits 3 down to 0 are V^H, F^H, F^V and F^V^H.
- R3: Within a line of L bytes with A active bytes, positions 0..3 carry the end-of-active code. Positions L-A-4..L-A-1 carry the start-of-active code, and positions L-A..L-1 carry the active samples. A sample accepted by a `px_valid`/`px_ready` handshake appears on `vid_data` one clock later.
- R4: Every other byte is blanking fill: 0x80 at even positions and 0x10 at odd positions. A line whose number lies outside first..last active line has V=1 and sends fill in its active region.
- R5: A field has `cfg_lines` lines. F starts at 0 and toggles at every field boundary.
- R6: Line length, active length, line count and the active window are sampled when the generator starts and at each field boundary. A change made during a field affects only the next field.
- R7: Flag bit 0 (end of field) is set on the same edge as the last byte of a field, when it is enabled.
- R8: Flag bit 1 (line reached) is set on the same edge as the first byte of line `cfg_irq_line`, when it is enabled.
- R9: Flags stay set until a 1 is written to the matching bit of `irq_ack`. The flag then reads 0 after the next edge. `irq` is the OR of the flags.
- R10: If `px_ready` is high while `px_valid` is low, fill is sent for that position and flag bit 2 (underrun) is set.
- R11: `hs_out` is high outside the active region of every line when enabled. `fs_out` is high during line 0 of each F=0 field when enabled in free-running mode. `fs_oe` is high only for an enabled output in free-running mode.
- R12: In locked mode the generator stays idle until an edge of `fs_in` of the selected polarity arrives (falling when `cfg_fs_neg`=1). It then sends exactly two fields and returns to idle.
- R13: In locked mode only the first such edge after reset starts output. Later edges are ignored until the next reset.
- R14: In free-running mode the stream starts within a few clocks of reset release and continues field after field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_line_len | input | HW | Bytes per line, codes included |
| cfg_act_len | input | HW | Active bytes per line |
| cfg_lines | input | VW | Lines per field |
| cfg_act_first | input | VW | First active line |
| cfg_act_last | input | VW | Last active line |
| cfg_irq_line | input | VW | Line that sets the line flag |
| cfg_irq_eof_en | input | 1 | Enable end-of-field flag |
| cfg_irq_line_en | input | 1 | Enable line flag |
| cfg_ext_sync | input | 1 | 1 selects locked mode |
| cfg_fs_neg | input | 1 | 1 selects the falling edge of fs_in |
| cfg_hs_en | input | 1 | Enable hs_out |
| cfg_fs_out_en | input | 1 | Enable fs_out and its drive |
| fs_in | input | 1 | External frame sync |
| px_data | input | 8 | Active sample byte |
| px_valid | input | 1 | Sample byte is valid |
| px_ready | output | 1 | Block takes a sample this clock |
| vid_data | output | 8 | Output byte stream |
| hs_out | output | 1 | Horizontal sync |
| fs_out | output | 1 | Frame sync |
| fs_oe | output | 1 | Output enable for the shared frame sync pin |
| irq_ack | input | 3 | Write-one-to-clear for flags |
| irq_flags | output | 3 | Sticky flags: [0] field end, [1] line, [2] underrun |
| irq | output | 1 | OR of the flags |

## Verification
The byte for a given counter position appears on `vid_data` one edge after that position, and `hs_out` and `fs_out` follow the same edge. The field-end, line and underrun flags are set on that same edge, with the byte they describe. An acknowledge clears its flag one edge later. The monitor locks onto the first 0xFF byte and then compares one expected item per clock at the falling edge. At that point it also checks that each flag was clear on the previous byte and set on the byte that triggers it. On the next item it checks that the acknowledged flag has cleared.

// File: rtl/vout_timing.sv
module vout_timing #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_line_len,
  input  logic [HW-1:0] cfg_act_len,
  input  logic [VW-1:0] cfg_lines,
  input  logic [VW-1:0] cfg_act_first,
  input  logic [VW-1:0] cfg_act_last,
  input  logic [VW-1:0] cfg_irq_line,
  input  logic          cfg_irq_eof_en,
  input  logic          cfg_irq_line_en,
  input  logic          cfg_ext_sync,
  input  logic          cfg_fs_neg,
  input  logic          cfg_hs_en,
  input  logic          cfg_fs_out_en,
  input  logic          fs_in,
  input  logic [7:0]    px_data,
  input  logic          px_valid,
  output logic          px_ready,
  output logic [7:0]    vid_data,
  output logic          hs_out,
  output logic          fs_out,
  output logic          fs_oe,
  input  logic [2:0]    irq_ack,
  output logic [2:0]    irq_flags,
  output logic          irq
);
  localparam logic [HW-1:0] H1 = 1;
  localparam logic [HW-1:0] H4 = 4;
  localparam logic [VW-1:0] V1 = 1;

  logic          run, used, ext_m;
  logic [1:0]    fleft, fs_warm;
  logic [2:0]    fs_s;
  logic [HW-1:0] s_len, s_act, hcnt;
  logic [VW-1:0] s_lines, s_first, s_last, vcnt;
  logic          fld;

  wire fs_edge = (fs_warm == 2'd3) &&
                 (cfg_fs_neg ? (fs_s[2] & ~fs_s[1]) : (~fs_s[2] & fs_s[1]));

  wire [HW-1:0] sav_pos = s_len - s_act - H4;
  wire line_end  = hcnt == s_len - H1;
  wire field_end = line_end && (vcnt == s_lines - V1);
  wire vblank    = (vcnt < s_first) || (vcnt > s_last);
  wire in_eav    = hcnt < H4;
  wire in_sav    = (hcnt >= sav_pos) && (hcnt < sav_pos + H4);
  wire in_act    = hcnt >= sav_pos + H4;
  wire [1:0] cpos = in_eav ? hcnt[1:0] : (hcnt[1:0] - sav_pos[1:0]);

  wire h = in_eav;
  wire [7:0] xy = {1'b1, fld, vblank, h, vblank ^ h, fld ^ h, fld ^ vblank, fld ^ vblank ^ h};
  wire [7:0] code = (cpos == 2'd0) ? 8'hFF : (cpos == 2'd3) ? xy : 8'h00;
  wire [7:0] fill = hcnt[0] ? 8'h10 : 8'h80;

  assign px_ready = run && in_act && !vblank;
  wire take     = px_ready && px_valid;
  wire underrun = px_ready && !px_valid;

  wire [7:0] nxt = !run ? 8'h10 :
                   (in_eav || in_sav) ? code :
                   take ? px_data : fill;

  wire set_eof  = run && field_end && cfg_irq_eof_en;
  wire set_line = run && (hcnt == '0) && (vcnt == cfg_irq_line) && cfg_irq_line_en;

  assign fs_oe = cfg_fs_out_en && !cfg_ext_sync;
  assign irq   = |irq_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; used <= 1'b0; ext_m <= 1'b0; fleft <= 2'd0;
      fs_s <= 3'b000; fs_warm <= 2'd0;
      s_len <= '0; s_act <= '0; s_lines <= '0; s_first <= '0; s_last <= '0;
      hcnt <= '0; vcnt <= '0; fld <= 1'b0;
      vid_data <= 8'h10; hs_out <= 1'b0; fs_out <= 1'b0; irq_flags <= 3'b000;
    end else begin
      fs_s <= {fs_s[1:0], fs_in};
      if (fs_warm != 2'd3) fs_warm <= fs_warm + 2'd1;

      vid_data  <= nxt;
      hs_out    <= run && cfg_hs_en && !in_act;
      fs_out    <= run && cfg_fs_out_en && !ext_m && (vcnt == '0) && !fld;
      irq_flags <= (irq_flags & ~irq_ack) | {underrun, set_line, set_eof};

      if (!run) begin
        s_len <= cfg_line_len; s_act <= cfg_act_len; s_lines <= cfg_lines;
        s_first <= cfg_act_first; s_last <= cfg_act_last;
        hcnt <= '0; vcnt <= '0; fld <= 1'b0;
        ext_m <= cfg_ext_sync;
        if (!cfg_ext_sync) begin
          run <= 1'b1;
        end else if (fs_edge && !used) begin
          run <= 1'b1; used <= 1'b1; fleft <= 2'd2;
        end
      end else begin
        hcnt <= line_end ? '0 : hcnt + H1;
        if (line_end) vcnt <= field_end ? '0 : vcnt + V1;
        if (field_end) begin
          fld <= ~fld;
          s_len <= cfg_line_len; s_act <= cfg_act_len; s_lines <= cfg_lines;
          s_first <= cfg_act_first; s_last <= cfg_act_last;
          if (ext_m) begin
            fleft <= fleft - 2'd1;
            if (fleft == 2'd1) run <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module vout_timing_chk #(
  parameter int HW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [HW-1:0] hcnt,
  input logic [7:0]    vid_data,
  input logic          px_ready,
  input logic          px_valid,
  input logic [7:0]    px_data,
  input logic [2:0]    irq_flags,
  input logic [2:0]    irq_ack
);
  localparam logic [HW-1:0] H3 = 3;

  assert_code_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hcnt == '0) |=> vid_data == 8'hFF);

  assert_code_xy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hcnt == H3) |=> (vid_data[7] &&
      vid_data[3:0] == {vid_data[5] ^ vid_data[4], vid_data[6] ^ vid_data[4],
                        vid_data[6] ^ vid_data[5], vid_data[6] ^ vid_data[5] ^ vid_data[4]}));

  assert_sample_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (px_ready && px_valid) |=> vid_data == $past(px_data));

  assert_underrun_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (px_ready && !px_valid) |=> irq_flags[2]);

  assert_sticky_eof_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags[0] && !irq_ack[0]) |=> irq_flags[0]);

  assert_idle_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> vid_data == 8'h10);
endmodule

bind vout_timing vout_timing_chk #(.HW(HW)) i_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .hcnt(hcnt), .vid_data(vid_data),
  .px_ready(px_ready), .px_valid(px_valid), .px_data(px_data),
  .irq_flags(irq_flags), .irq_ack(irq_ack)
);

// File: tb/test_vout_timing.sv
module test_vout_timing;
  localparam int HW = 12;
  localparam int VW = 11;
  localparam int L = 16, A = 4, N = 6, FIRST = 2, IRQL = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [HW-1:0] cfg_line_len, cfg_act_len;
  logic [VW-1:0] cfg_lines, cfg_act_first, cfg_act_last, cfg_irq_line;
  logic cfg_irq_eof_en, cfg_irq_line_en, cfg_ext_sync, cfg_fs_neg, cfg_hs_en, cfg_fs_out_en;
  logic fs_in;
  logic [7:0] px_data;
  logic px_valid, px_ready;
  logic [7:0] vid_data;
  logic hs_out, fs_out, fs_oe, irq;
  logic [2:0] irq_ack, irq_flags;

  vout_timing #(.HW(HW), .VW(VW)) i_vout_timing (
    .clk(clk), .rst_n(rst_n),
    .cfg_line_len(cfg_line_len), .cfg_act_len(cfg_act_len), .cfg_lines(cfg_lines),
    .cfg_act_first(cfg_act_first), .cfg_act_last(cfg_act_last), .cfg_irq_line(cfg_irq_line),
    .cfg_irq_eof_en(cfg_irq_eof_en), .cfg_irq_line_en(cfg_irq_line_en),
    .cfg_ext_sync(cfg_ext_sync), .cfg_fs_neg(cfg_fs_neg), .cfg_hs_en(cfg_hs_en),
    .cfg_fs_out_en(cfg_fs_out_en), .fs_in(fs_in), .px_data(px_data), .px_valid(px_valid),
    .px_ready(px_ready), .vid_data(vid_data), .hs_out(hs_out), .fs_out(fs_out),
    .fs_oe(fs_oe), .irq_ack(irq_ack), .irq_flags(irq_flags), .irq(irq)
  );

  int checks = 0, fails = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] q_d[$];
  logic       q_hs[$], q_fs[$];
  int         q_ev[$];
  string      q_rq[$];

  function automatic logic [7:0] tcode(input int p, input logic f, input logic v, input logic h);
    if (p == 0) return 8'hFF;
    if (p < 3) return 8'h00;
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  int pv_model;
  task automatic push_field(input logic f, input int last, input bit feed, input bit fs_en);
    for (int ln = 0; ln < N; ln++) begin
      for (int hp = 0; hp < L; hp++) begin
        logic v;
        logic [7:0] b;
        string rq;
        int ev;
        v = (ln < FIRST) || (ln > last);
        ev = 0;
        if (hp < 4) begin b = tcode(hp, f, v, 1'b1); rq = "R2 end code"; end
        else if (hp < L - A - 4) begin b = hp[0] ? 8'h10 : 8'h80; rq = "R4 hblank fill"; end
        else if (hp < L - A) begin b = tcode(hp - (L - A - 4), f, v, 1'b0); rq = "R3 start code"; end
        else if (v) begin b = hp[0] ? 8'h10 : 8'h80; rq = "R4 vblank fill"; end
        else if (feed) begin b = pv_model[7:0]; pv_model++; rq = "R3 sample"; end
        else begin b = hp[0] ? 8'h10 : 8'h80; rq = "R10 underrun fill"; end
        if (ln == IRQL && hp == 0) ev = 2;
        if (ln == N - 1 && hp == L - 1) ev = 1;
        q_d.push_back(b);
        q_hs.push_back(hp < L - A);
        q_fs.push_back(fs_en && ln == 0 && !f);
        q_ev.push_back(ev);
        q_rq.push_back(rq);
      end
    end
  endtask

  logic mon_on = 1'b0, aligned = 1'b0;
  int idx = 0, pend_bit = -1, und0_idx = -1, und1_idx = -1;
  logic [2:0] prev_fl = 3'b000;

  always @(negedge clk) begin
    logic [7:0] ed;
    logic eh, ef;
    int ev;
    string rq;
    if (mon_on && !aligned && vid_data == 8'hFF) aligned = 1'b1;
    if (pend_bit >= 0) begin
      chk("R9 flag cleared after ack", {31'd0, irq_flags[pend_bit]}, 0);
      irq_ack = 3'b000;
      pend_bit = -1;
    end
    if (mon_on && aligned && q_d.size() > 0) begin
      ed = q_d.pop_front(); eh = q_hs.pop_front(); ef = q_fs.pop_front();
      ev = q_ev.pop_front(); rq = q_rq.pop_front();
      chk(rq, {24'd0, vid_data}, {24'd0, ed});
      chk("R11 hs_out", {31'd0, hs_out}, {31'd0, eh});
      chk("R11 fs_out", {31'd0, fs_out}, {31'd0, ef});
      if (ev == 1) begin
        chk("R7 eof clear before last byte", {31'd0, prev_fl[0]}, 0);
        chk("R7 eof set with last byte", {31'd0, irq_flags[0]}, 1);
        chk("R9 irq output", {31'd0, irq}, 1);
        irq_ack = 3'b001; pend_bit = 0;
      end
      if (ev == 2) begin
        chk("R8 line flag clear before line", {31'd0, prev_fl[1]}, 0);
        chk("R8 line flag set", {31'd0, irq_flags[1]}, 1);
        irq_ack = 3'b010; pend_bit = 1;
      end
      if (idx == und0_idx) chk("R10 no underrun yet", {31'd0, irq_flags[2]}, 0);
      if (idx == und1_idx) chk("R10 R9 underrun flag sticky", {31'd0, irq_flags[2]}, 1);
      idx++;
    end
    prev_fl = irq_flags;
  end

  logic [7:0] pv_drv;
  logic hs_pend;
  always @(negedge clk) begin
    if (hs_pend) pv_drv = pv_drv + 8'd1;
    hs_pend = px_ready && px_valid;
    px_data = pv_drv;
  end

  task automatic idle_window(input string req, input int n);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (vid_data !== 8'h10) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic start_test(input logic ext);
    rst_n = 1'b0;
    mon_on = 1'b0; aligned = 1'b0; idx = 0;
    q_d.delete(); q_hs.delete(); q_fs.delete(); q_ev.delete(); q_rq.delete();
    cfg_line_len = L; cfg_act_len = A; cfg_lines = N;
    cfg_act_first = FIRST; cfg_act_last = 4; cfg_irq_line = IRQL;
    cfg_irq_eof_en = 1'b1; cfg_irq_line_en = 1'b1; cfg_hs_en = 1'b1;
    cfg_ext_sync = ext; cfg_fs_neg = 1'b1; cfg_fs_out_en = 1'b1;
    fs_in = 1'b0; px_valid = 1'b1; irq_ack = 3'b000; pend_bit = -1;
    pv_drv = 8'h20; hs_pend = 1'b0; pv_model = 32'h20;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_drain();
    while (q_d.size() > 0) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // Free-running mode
    start_test(1'b0);
    chk("R1 reset vid_data", {24'd0, vid_data}, 32'h10);
    chk("R1 reset flags", {29'd0, irq_flags}, 0);
    chk("R1 reset ready", {31'd0, px_ready}, 0);
    chk("R1 reset hs", {31'd0, hs_out}, 0);
    chk("R11 fs_oe free-running", {31'd0, fs_oe}, 1);
    push_field(1'b0, 4, 1'b1, 1'b1);
    push_field(1'b1, 3, 1'b1, 1'b1);
    push_field(1'b0, 3, 1'b0, 1'b1);
    und0_idx = 191; und1_idx = 287;
    mon_on = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R14 stream starts after reset", {31'd0, aligned}, 1);
    while (idx < 40) @(negedge clk);
    cfg_act_last = 3;          // R6: only from the next field
    while (idx < 170) @(negedge clk);
    px_valid = 1'b0;           // R10: source starves from field 2
    wait_drain();
    chk("R5 R14 three fields streamed", idx, 288);

    // Locked mode
    und0_idx = -1; und1_idx = -1;
    start_test(1'b1);
    chk("R11 fs_oe locked mode", {31'd0, fs_oe}, 0);
    rst_n = 1'b1;
    idle_window("R12 idle before edge", 30);
    fs_in = 1'b1;
    idle_window("R12 rising edge ignored with falling select", 30);
    push_field(1'b0, 4, 1'b1, 1'b0);
    push_field(1'b1, 4, 1'b1, 1'b0);
    mon_on = 1'b1;
    fs_in = 1'b0;
    wait_drain();
    chk("R12 two fields streamed", idx, 192);
    idle_window("R12 idle after two fields", 100);
    fs_in = 1'b1;
    repeat (5) @(negedge clk);
    fs_in = 1'b0;
    idle_window("R13 second edge ignored", 120);
    chk("R13 no extra bytes", {31'd0, aligned}, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule